// File: doc/BRIEF.md
# Outbound Completion Timeout Timer

This block guards a single outstanding outbound non-posted request. When the request goes out, a down-counter is loaded from a programmable 24-bit count. A divide-by-eight prescaler on the controller clock decrements it once every eight cycles. If the counter runs out before any response arrives, the block ends the request, emits a one-cycle timeout pulse and sets a sticky error flag, so the requester is never left waiting forever.

A 32-bit control word holds a disable flag in its top bit and the count in its low 24 bits. A count of zero is treated as the largest count rather than as an instant timeout. A normal completion ends the request quietly. An abort or error completion ends it and sets the sticky error flag. Software clears the flag with a write-one-to-clear strobe.

Top module: `cpl_timeout_timer`

## Requirements
- R1: After reset the control word reads 0x0010_FFFF, and `busy`, `tmo_pulse` and `err_sticky` are all 0.
- R2: A write stores bit 31 (disable flag) and bits 23:0 (count). Bits 30:24 always read as zero, whatever was written.
- R3: A `req_issue` pulse while idle sets `busy` in the next cycle and loads the counter from the count field.
- R4: With the disable flag at 0 and a count N other than zero, `busy` stays high for exactly 8*N cycles after the issuing edge. At the edge where it falls, `tmo_pulse` is high for exactly one cycle.
- R5: A count of 0 loads 2^24-1, so no timeout occurs soon after issue.
- R6: A `cpl_ok` pulse while busy clears `busy` in the next cycle, stops the counter and raises no error.
- R7: A `cpl_abort` pulse while busy clears `busy` in the next cycle and sets `err_sticky`.
- R8: A timeout sets `err_sticky`, and it stays set until cleared.
- R9: While the disable flag is 1 the counter does not advance and no timeout pulse is produced; `busy` holds until a completion arrives.
- R10: `sts_clr` clears `err_sticky` in the next cycle, unless a new error is raised in the same cycle, in which case the flag stays set.
- R11: A completion arriving in the same cycle as counter expiry wins: no timeout pulse, and `err_sticky` changes only when that completion is an abort.
- R12: A `req_issue` pulse while busy is ignored and does not reload the counter.
- R13: `cpl_ok` or `cpl_abort` while idle has no effect on `busy` or `err_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read value |
| sts_clr | input | 1 | Write-one-to-clear strobe for the sticky error |
| req_issue | input | 1 | Non-posted request issued (pulse) |
| cpl_ok | input | 1 | Successful completion received (pulse) |
| cpl_abort | input | 1 | Abort or error completion received (pulse) |
| tmo_pulse | output | 1 | One-cycle completion timeout indication |
| err_sticky | output | 1 | Sticky error status |
| busy | output | 1 | Request outstanding |

## Verification
Two pairs of events can land on the same clock edge: a completion and the counter's final tick, and a clear strobe and a new abort. The bench sweeps the completion arrival over every cycle offset from 1 to 8*N, for counts N from 1 to 4 and for both completion kinds, so the offset 8*N hits the expiry edge exactly. At that offset it expects no timeout pulse, and a sticky flag that depends only on the completion kind. It also drives `sts_clr` on the same edge as an abort and expects the flag to stay set.

// File: rtl/cto_pkg.sv
package cto_pkg;
    localparam int CTRL_W  = 32;
    localparam int CNT_W   = 24;
    localparam int DIS_BIT = 31;
    // writable bits of the control word: disable flag and count field
    localparam logic [CTRL_W-1:0] CTRL_WR_MASK = 32'h80FF_FFFF;
    localparam logic [CTRL_W-1:0] CTRL_RST     = 32'h0010_FFFF;

    typedef struct packed {
        logic busy;
        logic tmo;
        logic sticky;
    } stat_t;
endpackage

// File: rtl/cto_ctrl_reg.sv
module cto_ctrl_reg
    import cto_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_WORD = CTRL_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] word,
    output logic              dis,
    output logic [CNT_W-1:0]  cnt
);
    logic [CTRL_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            word_d = wdata & CTRL_WR_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= RESET_WORD & CTRL_WR_MASK;
        else        word_q <= word_d;
    end

    assign word = word_q;
    assign dis  = word_q[DIS_BIT];
    assign cnt  = word_q[CNT_W-1:0];
endmodule

// File: rtl/cto_prescaler.sv
module cto_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (restart) begin
            pre_d = '0;
        end else if (run) begin
            pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = run && !restart && (pre_q == LAST);
endmodule

// File: rtl/cto_down_counter.sv
module cto_down_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         at_one
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_one = (cnt_q == W'(1));
endmodule

// File: rtl/cpl_timeout_timer.sv
module cpl_timeout_timer
    import cto_pkg::*;
#(
    parameter int                PRESCALE   = 8,
    parameter logic [CTRL_W-1:0] RESET_WORD = CTRL_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              sts_clr,
    input  logic              req_issue,
    input  logic              cpl_ok,
    input  logic              cpl_abort,
    output logic              tmo_pulse,
    output logic              err_sticky,
    output logic              busy
);
    logic             dis;
    logic [CNT_W-1:0] cnt_field;
    logic [CNT_W-1:0] load_val;
    logic             accept, tick, at_one, done, expire, dec;
    stat_t            st_d, st_q;

    cto_ctrl_reg #(.RESET_WORD(RESET_WORD)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .word  (reg_rdata),
        .dis   (dis),
        .cnt   (cnt_field)
    );

    cto_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (st_q.busy),
        .tick    (tick)
    );

    cto_down_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (load_val),
        .dec      (dec),
        .at_one   (at_one)
    );

    always_comb begin
        // zero is reserved: run the longest possible window instead
        load_val = (cnt_field == '0) ? '1 : cnt_field;
        accept   = req_issue && !st_q.busy;
        done     = st_q.busy && (cpl_ok || cpl_abort);
        dec      = st_q.busy && tick && !dis;
        expire   = dec && at_one;

        st_d     = st_q;
        st_d.tmo = 1'b0;
        if (accept) begin
            st_d.busy = 1'b1;
        end else if (done || expire) begin
            st_d.busy = 1'b0;
        end
        // a completion on the expiry edge takes precedence
        if (expire && !done) begin
            st_d.tmo = 1'b1;
        end
        if (sts_clr) begin
            st_d.sticky = 1'b0;
        end
        if ((expire && !done) || (done && cpl_abort)) begin
            st_d.sticky = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = st_q.busy;
    assign tmo_pulse  = st_q.tmo;
    assign err_sticky = st_q.sticky;
endmodule

// File: rtl/cto_chk.sv
module cto_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        sts_clr,
    input logic        req_issue,
    input logic        cpl_ok,
    input logic        cpl_abort,
    input logic        tmo_pulse,
    input logic        err_sticky,
    input logic        busy
);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[30:24] == 7'd0);
    // R3
    issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_issue && !busy) |=> busy);
    // R4
    tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |=> !tmo_pulse);
    // R8
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |-> (err_sticky && !busy && $past(busy)));
    // R9
    dis_no_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |-> !$past(reg_rdata[31]));
    // R6
    cpl_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cpl_ok || cpl_abort)) |=> (!busy && !tmo_pulse));
    // R7
    abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpl_abort) |=> err_sticky);
    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_issue) |=> !busy);
    // R10
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !busy) |=> !err_sticky);
endmodule

bind cpl_timeout_timer cto_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rdata  (reg_rdata),
    .sts_clr    (sts_clr),
    .req_issue  (req_issue),
    .cpl_ok     (cpl_ok),
    .cpl_abort  (cpl_abort),
    .tmo_pulse  (tmo_pulse),
    .err_sticky (err_sticky),
    .busy       (busy)
);

// File: tb/sim_cpl_timeout_timer.sv
`timescale 1ns/1ps
module sim_cpl_timeout_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sts_clr = 1'b0;
    logic        req_issue = 1'b0;
    logic        cpl_ok = 1'b0;
    logic        cpl_abort = 1'b0;
    logic        tmo_pulse, err_sticky, busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    cpl_timeout_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sts_clr(sts_clr), .req_issue(req_issue),
        .cpl_ok(cpl_ok), .cpl_abort(cpl_abort), .tmo_pulse(tmo_pulse),
        .err_sticky(err_sticky), .busy(busy)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done_flag) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [31:0] v);
        reg_wr_en = 1'b1; reg_wdata = v; step(); reg_wr_en = 1'b0;
    endtask

    task automatic clear_sts();
        sts_clr = 1'b1; step(); sts_clr = 1'b0;
    endtask

    task automatic issue();
        req_issue = 1'b1; step(); req_issue = 1'b0;
    endtask

    task automatic finish_ok();
        cpl_ok = 1'b1; step(); cpl_ok = 1'b0;
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset values
        chk(reg_rdata == 32'h0010_FFFF, "R1 ctrl reset", reg_rdata, 32'h0010_FFFF);
        chk({busy, tmo_pulse, err_sticky} == 3'b000, "R1 status reset",
            {29'd0, busy, tmo_pulse, err_sticky}, 32'd0);

        // R2 reserved bits and writable fields
        write_reg(32'hFFFF_FFFF);
        chk(reg_rdata == 32'h80FF_FFFF, "R2 all ones", reg_rdata, 32'h80FF_FFFF);
        write_reg(32'h7F00_0000);
        chk(reg_rdata == 32'h0, "R2 reserved only", reg_rdata, 32'h0);

        // R13 completions while idle
        cpl_abort = 1'b1; step(); cpl_abort = 1'b0;
        finish_ok();
        chk(!busy && !err_sticky, "R13 idle completions", {30'd0, busy, err_sticky}, 32'd0);

        // R3 R4 R8 timeout sweep
        for (int n = 1; n <= 6; n++) begin
            bit ok;
            write_reg(32'(n));
            clear_sts();
            issue();
            chk(busy, "R3 busy after issue", {31'd0, busy}, 32'd1);
            ok = 1'b1;
            for (int c = 0; c < 8 * n; c++) begin
                if (!busy || tmo_pulse) ok = 1'b0;
                step();
            end
            chk(ok, "R4 busy held 8N cycles", {31'd0, ok}, 32'd1);
            chk(tmo_pulse && !busy, "R4 timeout at 8N", {30'd0, tmo_pulse, busy}, 32'd2);
            chk(err_sticky, "R8 sticky on timeout", {31'd0, err_sticky}, 32'd1);
            step();
            chk(!tmo_pulse && err_sticky, "R4 pulse one cycle, R8 sticky kept",
                {30'd0, tmo_pulse, err_sticky}, 32'd1);
        end

        // R6 R7 R11 completion sweep over every offset, including expiry edge
        for (int n = 1; n <= 4; n++) begin
            for (int k = 1; k <= 8 * n; k++) begin
                for (int ab = 0; ab < 2; ab++) begin
                    bit ok;
                    write_reg(32'(n));
                    clear_sts();
                    issue();
                    ok = 1'b1;
                    for (int c = 1; c < k; c++) begin
                        if (!busy || tmo_pulse) ok = 1'b0;
                        step();
                    end
                    chk(ok, "R6 busy before completion", {31'd0, ok}, 32'd1);
                    if (ab == 1) cpl_abort = 1'b1; else cpl_ok = 1'b1;
                    step();
                    cpl_abort = 1'b0; cpl_ok = 1'b0;
                    chk(!busy && !tmo_pulse && (err_sticky == ab[0]),
                        (k == 8 * n) ? "R11 completion at expiry" : (ab == 1 ? "R7 abort ends" : "R6 ok ends"),
                        {29'd0, busy, tmo_pulse, err_sticky}, {31'd0, ab[0]});
                    ok = 1'b1;
                    for (int c = 0; c < 8 * n + 2; c++) begin
                        if (tmo_pulse || busy) ok = 1'b0;
                        step();
                    end
                    chk(ok, "R11 no late timeout", {31'd0, ok}, 32'd1);
                end
            end
        end

        // R12 reissue while busy is ignored
        write_reg(32'd3);
        clear_sts();
        issue();
        for (int c = 1; c < 10; c++) step();
        issue();
        begin
            bit ok = 1'b1;
            for (int c = 10; c < 24; c++) begin
                if (!busy || tmo_pulse) ok = 1'b0;
                step();
            end
            chk(ok, "R12 busy until original expiry", {31'd0, ok}, 32'd1);
        end
        chk(tmo_pulse && !busy, "R12 timeout not reloaded", {30'd0, tmo_pulse, busy}, 32'd2);
        step();

        // R10 clear, and clear colliding with abort
        clear_sts();
        chk(!err_sticky, "R10 clear", {31'd0, err_sticky}, 32'd0);
        issue();
        step();
        sts_clr = 1'b1; cpl_abort = 1'b1; step(); sts_clr = 1'b0; cpl_abort = 1'b0;
        chk(err_sticky && !busy, "R10 set wins over clear", {30'd0, err_sticky, busy}, 32'd2);
        clear_sts();

        // R5 zero count acts as maximum
        write_reg(32'h0000_0000);
        issue();
        begin
            bit ok = 1'b1;
            for (int c = 0; c < 300; c++) begin
                if (!busy || tmo_pulse) ok = 1'b0;
                step();
            end
            chk(ok, "R5 zero count no early timeout", {31'd0, ok}, 32'd1);
        end
        finish_ok();
        chk(!busy && !err_sticky, "R5 completes quietly", {30'd0, busy, err_sticky}, 32'd0);

        // R9 disabled timer
        write_reg(32'h8000_0001);
        issue();
        begin
            bit ok = 1'b1;
            for (int c = 0; c < 64; c++) begin
                if (!busy || tmo_pulse) ok = 1'b0;
                step();
            end
            chk(ok, "R9 disabled holds busy", {31'd0, ok}, 32'd1);
        end
        finish_ok();
        chk(!busy && !err_sticky && !tmo_pulse, "R9 completion ends disabled wait",
            {29'd0, busy, err_sticky, tmo_pulse}, 32'd0);

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule